// File: doc/BRIEF.md
# Field-Reversal Pulse Count Analyzer

This block reads the output pulse stream of one charge-balancing integrator channel and turns it into a field-change figure. A run has three counted phases. A leading baseline phase counts pulses at zero input while the field is steady. An event phase counts pulses while the field is reversed. A trailing baseline phase counts the zero-input pulses again. The block then takes the mean of the two baseline rates and scales it to the event window length, rounding to nearest. This gives the count expected from drift alone. The block subtracts that count from the actual event count and reports the signed excess.

The excess is multiplied by an unsigned per-pulse scale factor to give a field change. For example, 20.0 G per pulse with four fractional bits is written as 320. The block also reports half of that value, which is the saturation field when the run sweeps from one saturated polarity to the other. A positive input to the integrator slows the pulses, so the excess can be negative. Phase lengths are set in time-base ticks, so a 20 s window at a 1 Hz tick is simply 20. The pulse counters are wide enough for the nominal 5000 pulses per second over such windows. They saturate rather than wrap.

Top module: `pulse_count_analyzer`

## Requirements
- R1: After reset, `done_o` and `overflow_o` are 0, and `excess_o`, `field_o` and `half_o` are all 0.
- R2: A `start_i` high while the block is idle starts a run. A `start_i` seen during any other phase has no effect on the run's timing or results.
- R3: Each phase ends on its Nth `tick_i` strobe, where N is the length latched at start (a length of 0 counts as 1). A `pulse_i` high in a cycle is counted by the phase current in that cycle. The phase order is leading baseline, event, trailing baseline.
- R4: The expected event count is floor(((B1 + B2) * E + B) / (2 * B)). B1 and B2 are the baseline counts, E is the event length and B is the baseline length. This equals the interpolated drift count rounded half up.
- R5: `excess_o` is the event count minus the expected count, as a two's-complement signed value.
- R6: `field_o` is `excess_o` multiplied by the unsigned `scale_i` latched at start. Any fractional bits of the scale carry through to `field_o` unchanged.
- R7: `half_o` is `field_o` arithmetically shifted right by one bit, which rounds toward minus infinity.
- R8: Each pulse counter stops at 2^CNT_W-1. A pulse arriving at a full counter sets `overflow_o`. The flag stays set until the next accepted start.
- R9: `done_o` is high for exactly one cycle per run. The three results change only in that cycle and hold their values afterwards.
- R10: Changing `base_len_i`, `evt_len_i` or `scale_i` after a run has started does not alter that run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Integrator pulse, one count per high cycle |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| start_i | input | 1 | Run request, honoured only when idle |
| base_len_i | input | LEN_W | Baseline phase length in ticks |
| evt_len_i | input | LEN_W | Event phase length in ticks |
| scale_i | input | SCALE_W | Field units per excess pulse (fixed point) |
| excess_o | output | NUM_W+1 | Signed excess pulse count |
| field_o | output | NUM_W+SCALE_W+2 | Signed field change |
| half_o | output | NUM_W+SCALE_W+2 | Signed half of field change |
| done_o | output | 1 | One-cycle result strobe |
| overflow_o | output | 1 | Sticky counter saturation flag |

## Verification
If the phase tracking drifts by one tick, pulses are counted in the wrong phase. That error appears in `excess_o` at the next `done_o`, about one divider latency after the last tick. A faulty divider step or a bad rounding offset shows as an excess that is off by one. Uneven pulse counts are chosen so that each of these errors changes the result. A counter that wraps instead of holding shows up as a very different excess, and also as a missing `overflow_o`, in the same run that overflowed.

// File: rtl/pca_pkg.sv
package pca_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BASE1 = 3'd1,
        PH_EVENT = 3'd2,
        PH_BASE2 = 3'd3,
        PH_CALC  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    localparam int NUM_COUNT_PHASES = 3;

    function automatic logic is_counting(input phase_e p);
        return (p == PH_BASE1) || (p == PH_EVENT) || (p == PH_BASE2);
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_BASE1: return PH_EVENT;
            PH_EVENT: return PH_BASE2;
            PH_BASE2: return PH_CALC;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pca_sat_counter.sv
module pca_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);
    localparam logic [W-1:0] TOP = '1;

    logic full;
    assign full  = (cnt_o == TOP);
    assign hit_o = inc_i && full && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && !full) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/pca_divider.sv
module pca_divider #(
    parameter int NUM_W = 66,
    parameter int DEN_W = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             done_o
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] quo;
    logic [CW-1:0]    steps;
    logic             busy;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    assign shifted = {rem, quo[NUM_W-1]};
    assign diff    = shifted - {1'b0, den_q};
    assign fits    = (shifted >= {1'b0, den_q});
    assign quo_o   = quo;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            den_q  <= '0;
            quo    <= '0;
            steps  <= '0;
            busy   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                rem   <= '0;
                quo   <= num_i;
                den_q <= den_i;
                steps <= CW'(NUM_W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem   <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                quo   <= {quo[NUM_W-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == CW'(1)) begin
                    busy   <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pca_phase_ctrl.sv
module pca_phase_ctrl
    import pca_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] base_len_i,
    input  logic [LEN_W-1:0] evt_len_i,
    input  logic             div_done_i,
    output phase_e           phase_o,
    output logic             run_start_o,
    output logic             calc_go_o,
    output logic [LEN_W-1:0] base_eff_o,
    output logic [LEN_W-1:0] evt_eff_o
);
    logic [LEN_W-1:0] tick_cnt;
    logic [LEN_W-1:0] cur_len;
    logic             last_tick;

    assign run_start_o = (phase_o == PH_IDLE) && start_i;
    assign cur_len     = (phase_o == PH_EVENT) ? evt_eff_o : base_eff_o;
    assign last_tick   = tick_i && (tick_cnt == cur_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o    <= PH_IDLE;
            tick_cnt   <= '0;
            calc_go_o  <= 1'b0;
            base_eff_o <= '0;
            evt_eff_o  <= '0;
        end else begin
            calc_go_o <= 1'b0;
            case (phase_o)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_o    <= PH_BASE1;
                        tick_cnt   <= '0;
                        base_eff_o <= (base_len_i == '0) ? LEN_W'(1) : base_len_i;
                        evt_eff_o  <= (evt_len_i == '0) ? LEN_W'(1) : evt_len_i;
                    end
                end
                PH_BASE1, PH_EVENT, PH_BASE2: begin
                    if (last_tick) begin
                        tick_cnt <= '0;
                        phase_o  <= next_phase(phase_o);
                        if (phase_o == PH_BASE2) begin
                            calc_go_o <= 1'b1;
                        end
                    end else if (tick_i) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                PH_CALC: begin
                    if (div_done_i) begin
                        phase_o <= PH_DONE;
                    end
                end
                default: begin
                    phase_o <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/pulse_count_analyzer.sv
module pulse_count_analyzer
    import pca_pkg::*;
#(
    parameter  int CNT_W   = 32,
    parameter  int LEN_W   = 32,
    parameter  int SCALE_W = 16,
    localparam int NUM_W   = CNT_W + LEN_W + 2,
    localparam int EX_W    = NUM_W + 1,
    localparam int FLD_W   = EX_W + SCALE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pulse_i,
    input  logic                    tick_i,
    input  logic                    start_i,
    input  logic [LEN_W-1:0]        base_len_i,
    input  logic [LEN_W-1:0]        evt_len_i,
    input  logic [SCALE_W-1:0]      scale_i,
    output logic signed [EX_W-1:0]  excess_o,
    output logic signed [FLD_W-1:0] field_o,
    output logic signed [FLD_W-1:0] half_o,
    output logic                    done_o,
    output logic                    overflow_o
);
    localparam int DEN_W = LEN_W + 1;

    phase_e                     phase;
    logic                       run_start;
    logic                       calc_go;
    logic                       div_done;
    logic [LEN_W-1:0]           base_eff;
    logic [LEN_W-1:0]           evt_eff;
    logic [SCALE_W-1:0]         scale_q;
    logic [CNT_W-1:0]           cnt [NUM_COUNT_PHASES];
    logic [NUM_COUNT_PHASES-1:0] hit;
    logic [NUM_W-1:0]           num;
    logic [DEN_W-1:0]           den;
    logic [NUM_W-1:0]           quo;
    logic signed [EX_W-1:0]     excess_c;
    logic signed [FLD_W-1:0]    ex_w;
    logic signed [FLD_W-1:0]    sc_w;
    logic signed [FLD_W-1:0]    field_c;

    pca_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .tick_i      (tick_i),
        .base_len_i  (base_len_i),
        .evt_len_i   (evt_len_i),
        .div_done_i  (div_done),
        .phase_o     (phase),
        .run_start_o (run_start),
        .calc_go_o   (calc_go),
        .base_eff_o  (base_eff),
        .evt_eff_o   (evt_eff)
    );

    for (genvar k = 0; k < NUM_COUNT_PHASES; k++) begin : g_cnt
        localparam int PK = int'(PH_BASE1) + k;
        pca_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr_i (run_start),
            .inc_i (pulse_i && (int'(phase) == PK)),
            .cnt_o (cnt[k]),
            .hit_o (hit[k])
        );
    end

    // rounded drift estimate: ((B1+B2)*E + B) / (2B)
    assign num = NUM_W'({1'b0, cnt[0]} + {1'b0, cnt[2]}) * NUM_W'(evt_eff)
               + NUM_W'(base_eff);
    assign den = {base_eff, 1'b0};

    pca_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go_i   (calc_go),
        .num_i  (num),
        .den_i  (den),
        .quo_o  (quo),
        .done_o (div_done)
    );

    assign excess_c = $signed({{(EX_W-CNT_W){1'b0}}, cnt[1]}) - $signed({1'b0, quo});
    assign ex_w     = FLD_W'(excess_c);
    assign sc_w     = FLD_W'($signed({1'b0, scale_q}));
    assign field_c  = ex_w * sc_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q    <= '0;
            excess_o   <= '0;
            field_o    <= '0;
            half_o     <= '0;
            overflow_o <= 1'b0;
        end else begin
            if (run_start) begin
                scale_q    <= scale_i;
                overflow_o <= 1'b0;
            end else if (|hit) begin
                overflow_o <= 1'b1;
            end
            if (div_done && phase == PH_CALC) begin
                excess_o <= excess_c;
                field_o  <= field_c;
                half_o   <= field_c >>> 1;
            end
        end
    end

    assign done_o = (phase == PH_DONE);

endmodule

// File: rtl/pca_checker.sv
module pca_checker
    import pca_pkg::*;
#(
    parameter int EX_W  = 67,
    parameter int FLD_W = 84
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start_i,
    input phase_e                  phase,
    input logic                    done_o,
    input logic                    overflow_o,
    input logic signed [EX_W-1:0]  excess_o,
    input logic signed [FLD_W-1:0] field_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !($stable(excess_o) && $stable(field_o)) |-> done_o);  // R9

    AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (is_counting(phase) || phase == PH_CALC) |=> phase != PH_IDLE && phase != PH_BASE1 || $past(phase) == PH_BASE1);  // R2

    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start_i) |=> phase == PH_IDLE);  // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !(phase == PH_IDLE && start_i)) |=> overflow_o);  // R8

    AST_DONE_FROM_CALC: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(phase) == PH_CALC);  // R3
endmodule

bind pulse_count_analyzer pca_checker #(.EX_W(EX_W), .FLD_W(FLD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .phase      (phase),
    .done_o     (done_o),
    .overflow_o (overflow_o),
    .excess_o   (excess_o),
    .field_o    (field_o)
);

// File: tb/sim_pulse_count_analyzer.sv
module sim_pulse_count_analyzer;
    localparam int CNT_W   = 8;
    localparam int LEN_W   = 8;
    localparam int SCALE_W = 12;
    localparam int NUM_W   = CNT_W + LEN_W + 2;
    localparam int EX_W    = NUM_W + 1;
    localparam int FLD_W   = EX_W + SCALE_W + 1;

    typedef struct {
        longint ex;
        longint fld;
        longint half;
        bit     ovf;
        string  tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pulse_i = 1'b0, tick_i = 1'b0, start_i = 1'b0;
    logic [LEN_W-1:0]   base_len_i = '0, evt_len_i = '0;
    logic [SCALE_W-1:0] scale_i = '0;
    logic signed [EX_W-1:0]  excess_o;
    logic signed [FLD_W-1:0] field_o, half_o;
    logic done_o, overflow_o;

    exp_t q[$];
    int checks = 0, fails = 0, issued = 0, completed = 0;

    always #10 clk = ~clk;

    pulse_count_analyzer #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SCALE_W(SCALE_W)) u0 (
        .clk(clk), .rst(rst), .pulse_i(pulse_i), .tick_i(tick_i), .start_i(start_i),
        .base_len_i(base_len_i), .evt_len_i(evt_len_i), .scale_i(scale_i),
        .excess_o(excess_o), .field_o(field_o), .half_o(half_o),
        .done_o(done_o), .overflow_o(overflow_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_phase(input int len, input int n, input bit poke);
        for (int t = 0; t < len; t++) begin
            int p;
            p = n / len + ((t < n % len) ? 1 : 0);
            for (int i = 0; i < p; i++) begin
                @(negedge clk); pulse_i = 1'b1;
            end
            @(negedge clk); pulse_i = 1'b0;
            if (poke && t == 0) begin
                start_i = 1'b1; base_len_i = 8'd99; evt_len_i = 8'd1; scale_i = 12'd7;
            end
            @(negedge clk); start_i = 1'b0; tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic run(input string tag, input int bl, input int el, input int n1,
                       input int ne, input int n2, input int sc, input bit poke);
        exp_t e;
        longint mx, b, ev, b1, b2, be, ee, xp;
        mx = (64'd1 << CNT_W) - 1;
        be = (bl == 0) ? 1 : bl;
        ee = (el == 0) ? 1 : el;
        b1 = (n1 > mx) ? mx : n1;
        ev = (ne > mx) ? mx : ne;
        b2 = (n2 > mx) ? mx : n2;
        b  = be;
        xp = ((b1 + b2) * ee + b) / (2 * b);
        e.ex   = ev - xp;
        e.fld  = e.ex * sc;
        e.half = e.fld >>> 1;
        e.ovf  = (n1 > mx) || (ne > mx) || (n2 > mx);
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        start_i = 1'b1; base_len_i = LEN_W'(bl); evt_len_i = LEN_W'(el); scale_i = SCALE_W'(sc);
        @(negedge clk); start_i = 1'b0;
        drive_phase(int'(be), n1, 1'b0);
        drive_phase(int'(ee), ne, poke);
        drive_phase(int'(be), n2, 1'b0);
        issued++;
        wait (completed == issued);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_o) begin
                exp_t e;
                longint ex0, f0, h0;
                if (q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    ex0 = longint'(excess_o); f0 = longint'(field_o); h0 = longint'(half_o);
                    check(ex0 == e.ex,   "R4 R5", {e.tag, " excess"}, ex0, e.ex);
                    check(f0 == e.fld,   "R6",    {e.tag, " field"},  f0,  e.fld);
                    check(h0 == e.half,  "R7",    {e.tag, " half"},   h0,  e.half);
                    check(overflow_o == e.ovf, "R8", {e.tag, " overflow"},
                          longint'(overflow_o), longint'(e.ovf));
                    @(negedge clk);
                    check(!done_o, "R9", {e.tag, " done width"}, longint'(done_o), 0);
                    check(longint'(excess_o) == ex0 && longint'(field_o) == f0,
                          "R9", {e.tag, " hold"}, longint'(excess_o), ex0);
                end
                completed++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done_o == 1'b0 && overflow_o == 1'b0, "R1", "flags", longint'({done_o, overflow_o}), 0);
        check(excess_o == '0 && field_o == '0 && half_o == '0, "R1", "results",
              longint'(excess_o), 0);
        // R3 R4 steady baseline, no excess
        run("flat",      4, 6, 40, 60, 40, 320, 1'b0);
        // R5 positive excess
        run("positive",  4, 6, 40, 90, 40, 320, 1'b0);
        // R5 R7 negative excess with baseline drift
        run("negative",  4, 6, 30, 20, 50, 320, 1'b0);
        // R4 round half up, R7 floor on odd field
        run("round",     3, 5, 10, 17, 11, 21,  1'b0);
        // R8 saturation of event counter
        run("saturate",  2, 10, 20, 300, 20, 320, 1'b0);
        // R3 zero lengths behave as one tick; R8 flag cleared by new start
        run("zero_len",  0, 0, 5, 3, 7, 320, 1'b0);
        // R2 R10 start and setting changes mid-run ignored
        run("poke",      5, 4, 25, 37, 35, 320, 1'b1);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule